// File: doc/BRIEF.md
# UART-to-Fiber Frequency-Shift Encoder

This block sits between the transmit pin of a UART running 8N1 framing and an AC-coupled optical transmitter. The optical receiver only passes alternating signals, so a raw UART level cannot drive it. The block therefore re-times the UART line into fixed fiber bit slots. Each slot carries a square wave, and the number of periods in the slot gives the bit value. A slot carrying a zero holds a single long period. A slot carrying a one holds two periods at twice that frequency. Every slot opens with a rising edge, so a decoder on the far side does not have to recover the phase.

Three run-time inputs set the behaviour. The slot length is given in system clocks. A ratio sets how many slots make up one UART bit, so the UART rate is the clock divided by the product of the two. A direct mode skips framing: the encoder then takes the synchronised TX level at each slot boundary, which lets much slower UARTs pass as oversampled data. In framed mode the block waits for a start bit and samples the ten frame positions at their centres. It holds each sampled level for exactly one UART bit time. After the stop bit it re-arms early, so that the next start bit is caught even when the sender's clock runs slightly fast.

Top module: `fsk_fiber_encoder`

## Requirements
- R1: A slot that carries a 0 is high for the first floor(P/2) clocks of the slot and low for the rest, where P is `slot_len`.
- R2: A slot that carries a 1 is high for clocks [0, floor(P/4)) and [floor(P/2), floor(P/2)+floor(P/4)) of the slot, and low for the other clocks.
- R3: Slots follow each other back to back, each exactly P clocks long, and each starts with a rising edge on `fiber_out`. P values from 20 to 100 are supported.
- R4: In framed mode, each UART level is held on the fiber for exactly `slot_ratio` consecutive slots, with the start bit sent as 0.
- R5: In framed mode, a low on the synchronised TX line while idle starts a frame. The start bit and the eight data bits (LSB first) are each sampled at the centre of their UART bit time, whose length is `slot_len` × `slot_ratio` clocks.
- R6: After a valid stop bit, the framer is ready for the next start bit three quarters of the way through the stop bit when `slot_ratio` is 4 or more, and at the end of the stop bit otherwise. Back-to-back bytes from a sender about 2.5 % fast are therefore carried intact at ratio 4.
- R7: When `direct_en` is high, framing is bypassed. The bit that enters each slot is the synchronised TX level at the slot boundary, so a low TX of N×P clocks gives exactly N zero slots.
- R8: After reset the framer is idle and the line sends 1 slots. The TX input passes through a synchroniser of at least two flops, and `fiber_out` comes directly from a flop.
- R9: A stop bit sampled low sends 1 and makes the framer wait for TX to return high before it looks for a new start bit. A long break therefore produces no further frames, and the next valid byte is carried correctly.
- R10: A start bit that is high again at its centre is a false start. The framer returns to idle and no 0 slot is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_tx | input | 1 | UART transmit line, asynchronous, idle high |
| slot_len | input | SLOT_W | Fiber slot length in clocks (P) |
| slot_ratio | input | DIV_W | Fiber slots per UART bit, at least 1 |
| direct_en | input | 1 | 1 = pass TX level straight to the encoder, 0 = framed mode |
| fiber_out | output | 1 | Registered line-coded optical drive |

## Verification
The assertions take for granted that `slot_len` is at least 4 and stays fixed while the block runs out of reset. Shorter slots would merge the quarter-period phases, and a change of P in the middle of a slot would break the slot-edge properties. The stimulus therefore picks one configuration, resets, and only then runs traffic. The configurations sweep P across 20, 23, 40 and 100 and the ratio across 1 to 4. The framed-mode stimulus sends UART frames at exactly P × ratio clocks per bit, apart from the fast-sender case, which shortens each bit by two clocks and stays inside the stop-bit re-arm margin.

// File: rtl/fsk_enc_pkg.sv
package fsk_enc_pkg;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_DATA = 2'd1,
      FR_TAIL = 2'd2,
      FR_HUNT = 2'd3
   } fr_state_t;

   // frame positions: start, 8 data, stop
   localparam int FRAME_LAST_POS  = 9;
   // ratio from which the early (3/4 stop) re-arm is used
   localparam int REARM_MIN_RATIO = 4;

endpackage

// File: rtl/fsk_sync.sv
module fsk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fsk_framer.sv
module fsk_framer
   import fsk_enc_pkg::*;
#(
   parameter int SLOT_W = 7,
   parameter int DIV_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_s,
   input  logic [SLOT_W-1:0] slot_len,
   input  logic [DIV_W-1:0]  slot_ratio,
   input  logic              hold_idle,
   output logic              frame_bit
);

   localparam int BL_W = SLOT_W + DIV_W;

   fr_state_t       state;
   logic [BL_W-1:0] cnt, bit_len, half_len, tail_len, lim;
   logic [3:0]      pos;
   logic            first;
   logic            lim_hit, tail_hit;

   assign bit_len  = BL_W'(slot_len) * BL_W'(slot_ratio);
   assign half_len = bit_len >> 1;
   assign tail_len = (slot_ratio >= DIV_W'(REARM_MIN_RATIO)) ? (bit_len >> 2) : half_len;
   assign lim      = first ? half_len : bit_len;
   assign lim_hit  = ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
   assign tail_hit = ({1'b0, cnt} + 1'b1) >= {1'b0, tail_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FR_IDLE;
         cnt       <= '0;
         pos       <= '0;
         first     <= 1'b1;
         frame_bit <= 1'b1;
      end else if (hold_idle) begin
         state     <= FR_IDLE;
         cnt       <= '0;
         frame_bit <= 1'b1;
      end else begin
         unique case (state)
            FR_IDLE: begin
               if (!tx_s) begin
                  state <= FR_DATA;
                  cnt   <= '0;
                  pos   <= '0;
                  first <= 1'b1;
               end
            end
            FR_DATA: begin
               if (lim_hit) begin
                  cnt   <= '0;
                  first <= 1'b0;
                  if (pos == 4'd0) begin
                     if (tx_s) state <= FR_IDLE;   // false start
                     else      frame_bit <= 1'b0;
                     pos <= 4'd1;
                  end else if (pos == 4'(FRAME_LAST_POS)) begin
                     frame_bit <= 1'b1;
                     state     <= tx_s ? FR_TAIL : FR_HUNT;
                  end else begin
                     frame_bit <= tx_s;
                     pos       <= pos + 4'd1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FR_TAIL: begin
               if (tail_hit) state <= FR_IDLE;
               else          cnt   <= cnt + 1'b1;
            end
            FR_HUNT: begin
               if (tx_s) state <= FR_IDLE;
            end
            default: state <= FR_IDLE;
         endcase
      end
   end

   // idle line carries the 1 code
   assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_IDLE) |-> frame_bit);

   // after framing error the line stays at 1 until TX recovers
   assert_hunt_line_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_HUNT) |-> frame_bit);

   // an accepted start bit puts 0 on the line
   assert_start_sends_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_DATA && pos == 4'd1 && $past(pos) == 4'd0) |-> !frame_bit);

   // the re-arm wait never exceeds its programmed length
   assert_tail_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_TAIL) |-> (cnt < tail_len));

endmodule

// File: rtl/fsk_slot_mod.sv
module fsk_slot_mod #(
   parameter int SLOT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] slot_len,
   input  logic              line_bit,
   output logic              fiber_out
);

   logic [SLOT_W-1:0] sc, half_c, quart_c;
   logic              cur_bit, wave, slot_end;

   assign half_c   = slot_len >> 1;
   assign quart_c  = slot_len >> 2;
   assign slot_end = (sc >= slot_len - 1'b1);

   always_comb begin
      if (cur_bit) wave = (sc < quart_c) || ((sc >= half_c) && (sc < half_c + quart_c));
      else         wave = (sc < half_c);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc        <= '0;
         cur_bit   <= 1'b1;
         fiber_out <= 1'b0;
      end else begin
         fiber_out <= wave;
         if (slot_end) begin
            sc      <= '0;
            cur_bit <= line_bit;
         end else begin
            sc <= sc + 1'b1;
         end
      end
   end

   // every slot opens high
   assert_slot_opens_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sc == SLOT_W'(1) && slot_len >= SLOT_W'(4)) |-> fiber_out);

   // every slot closes low, giving the rising edge at the next slot
   assert_slot_closes_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sc == '0 && slot_len >= SLOT_W'(4)) |-> !fiber_out);

   // encoded bit is fixed for the whole slot
   assert_bit_held_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sc != '0) |-> $stable(cur_bit));

endmodule

// File: rtl/fsk_fiber_encoder.sv
module fsk_fiber_encoder #(
   parameter int SLOT_W      = 7,
   parameter int DIV_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uart_tx,
   input  logic [SLOT_W-1:0] slot_len,
   input  logic [DIV_W-1:0]  slot_ratio,
   input  logic              direct_en,
   output logic              fiber_out
);

   generate
      if (SLOT_W < 7) begin : g_bad_slot_w
         $error("fsk_fiber_encoder: SLOT_W must be at least 7");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("fsk_fiber_encoder: DIV_W must be at least 1");
      end
   endgenerate

   logic tx_s, frame_bit, line_bit;

   fsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (uart_tx),
      .q     (tx_s)
   );

   fsk_framer #(.SLOT_W(SLOT_W), .DIV_W(DIV_W)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_s       (tx_s),
      .slot_len   (slot_len),
      .slot_ratio (slot_ratio),
      .hold_idle  (direct_en),
      .frame_bit  (frame_bit)
   );

   assign line_bit = direct_en ? tx_s : frame_bit;

   fsk_slot_mod #(.SLOT_W(SLOT_W)) u_mod (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_len  (slot_len),
      .line_bit  (line_bit),
      .fiber_out (fiber_out)
   );

   // framer is parked while direct mode is on
   assert_direct_parks_framer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(direct_en) |-> frame_bit);

endmodule

// File: tb/test_fsk_fiber_encoder.sv
module test_fsk_fiber_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int MAXS       = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uart_tx = 1'b1;
   logic       direct_en = 1'b0;
   logic [6:0] slot_len = 7'd20;
   logic [6:0] slot_ratio = 7'd1;
   wire        fiber_out;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fsk_fiber_encoder i_fsk_fiber_encoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .uart_tx    (uart_tx),
      .slot_len   (slot_len),
      .slot_ratio (slot_ratio),
      .direct_en  (direct_en),
      .fiber_out  (fiber_out)
   );

   // slot monitor: classifies each P-clock window of fiber_out
   int  cur_p = 20;
   bit  mon_en = 1'b0;
   bit  slots [MAXS];
   int  nslots = 0;
   int  c_in = 0;
   bit  m0 = 1'b1, m1 = 1'b1;
   int  mh, mq;
   bit  e0, e1;

   always @(negedge clk) begin
      if (!mon_en) begin
         c_in = 0; m0 = 1'b1; m1 = 1'b1;
      end else begin
         mh = cur_p / 2;
         mq = cur_p / 4;
         e0 = (c_in < mh);
         e1 = (c_in < mq) || (c_in >= mh && c_in < mh + mq);
         if (fiber_out !== e0) m0 = 1'b0;
         if (fiber_out !== e1) m1 = 1'b0;
         if (c_in == cur_p - 1) begin
            checks++;
            if (m1 || m0) begin
               if (nslots < MAXS) slots[nslots] = m1;
               nslots++;
            end else begin
               errors++;
               $display("FAIL R1 R2 R3: slot %0d with P=%0d matches no code (actual: invalid, expected: 0 or 1 pattern)",
                        nslots, cur_p);
            end
            c_in = 0; m0 = 1'b1; m1 = 1'b1;
         end else begin
            c_in++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic start_cfg(input int p, input int r, input bit d);
      mon_en    = 1'b0;
      rst_n     = 1'b0;
      slot_len  = 7'(p);
      slot_ratio = 7'(r);
      direct_en = d;
      uart_tx   = 1'b1;
      cur_p     = p;
      nslots    = 0;
      repeat (3) @(negedge clk);
      chk(fiber_out == 1'b0, "R8", "output during reset", int'(fiber_out), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1 mon_en = 1'b1;
      repeat (5 * p) @(negedge clk);
      for (int i = 0; i < 4; i++)
         chk(nslots > i && slots[i] == 1'b1, "R8", "slot after reset", int'(slots[i]), 1);
   endtask

   task automatic idle_clocks(input int n);
      uart_tx = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input int bitclk, input bit stop_val);
      for (int k = 0; k < 10; k++) begin
         if (k == 0)      uart_tx = 1'b0;
         else if (k == 9) uart_tx = stop_val;
         else             uart_tx = b[k-1];
         repeat (bitclk) @(negedge clk);
      end
   endtask

   // find next start slot from pos and read 8 data bits at run centres
   task automatic decode(inout int pos, input int r, output int val, output int s);
      s = -1;
      val = 0;
      for (int i = pos; i < nslots; i++) begin
         if (!slots[i]) begin s = i; break; end
      end
      if (s >= 0) begin
         for (int k = 0; k < 8; k++) begin
            int idx;
            idx = s + r * (k + 1) + r / 2;
            if (idx < nslots && slots[idx]) val |= (1 << k);
         end
         pos = s + 9 * r;
      end
   endtask

   function automatic int count_zeros();
      int z = 0;
      for (int i = 0; i < nslots; i++) if (!slots[i]) z++;
      return z;
   endfunction

   int ps [5] = '{20, 20, 40, 23, 100};
   int rs [5] = '{1, 4, 2, 3, 1};
   logic [7:0] pat [5] = '{8'h55, 8'h00, 8'hFF, 8'hA3, 8'h3C};
   logic [7:0] fast [4] = '{8'h12, 8'h9A, 8'hF0, 8'h0F};

   initial begin
      int p, r, pos, val, s, bl;
      // sweep of slot length and ratio
      for (int c = 0; c < 5; c++) begin
         p = ps[c]; r = rs[c]; bl = p * r;
         start_cfg(p, r, 1'b0);
         for (int b = 0; b < 5; b++) begin
            send_byte(pat[b], bl, 1'b1);
            idle_clocks(2 * bl);
         end
         idle_clocks(3 * bl);
         pos = 0;
         for (int b = 0; b < 5; b++) begin
            decode(pos, r, val, s);
            chk(s >= 0, "R5", "start slot found", s, 0);
            chk(val == int'(pat[b]), "R5", "decoded byte", val, int'(pat[b]));
            if (b == 0 && s > 0) begin
               // R4: alternating 0x55 gives runs of exactly r slots
               chk(slots[s-1] == 1'b1, "R4", "slot before start", int'(slots[s-1]), 1);
               for (int j = 0; j < 9 * r; j++) begin
                  int lvl;
                  lvl = (j / r == 0) ? 0 : int'(pat[0][j / r - 1]);
                  chk(int'(slots[s+j]) == lvl, "R4", "run slot level", int'(slots[s+j]), lvl);
               end
            end
         end
      end

      // R6: back-to-back bytes, sender bit time 78 instead of 80
      start_cfg(20, 4, 1'b0);
      for (int b = 0; b < 4; b++) send_byte(fast[b], 78, 1'b1);
      idle_clocks(300);
      pos = 0;
      for (int b = 0; b < 4; b++) begin
         decode(pos, 4, val, s);
         chk(s >= 0 && val == int'(fast[b]), "R6", "fast back-to-back byte", val, int'(fast[b]));
      end

      // R9: framing error with a long break, then a valid byte
      start_cfg(20, 2, 1'b0);
      send_byte(8'hFF, 40, 1'b0);
      uart_tx = 1'b0;
      repeat (160) @(negedge clk);
      idle_clocks(160);
      send_byte(8'hA5, 40, 1'b1);
      idle_clocks(160);
      pos = 0;
      decode(pos, 2, val, s);
      chk(s >= 0 && val == 8'hFF, "R9", "frame before break", val, 8'hFF);
      decode(pos, 2, val, s);
      chk(s >= 0 && val == 8'hA5, "R9", "byte after break", val, 8'hA5);

      // R10: short low glitch is a false start
      start_cfg(20, 4, 1'b0);
      uart_tx = 1'b0;
      repeat (15) @(negedge clk);
      idle_clocks(800);
      chk(count_zeros() == 0, "R10", "zero slots after glitch", count_zeros(), 0);
      send_byte(8'h5A, 80, 1'b1);
      idle_clocks(240);
      pos = 0;
      decode(pos, 4, val, s);
      chk(s >= 0 && val == 8'h5A, "R10", "byte after glitch", val, 8'h5A);

      // R7: direct mode, TX low for 10 slot times
      start_cfg(20, 1, 1'b1);
      uart_tx = 1'b0;
      repeat (200) @(negedge clk);
      idle_clocks(400);
      chk(count_zeros() == 10, "R7", "direct-mode zero slots", count_zeros(), 10);
      uart_tx = 1'b0;
      repeat (60) @(negedge clk);
      idle_clocks(200);
      chk(count_zeros() == 13, "R7", "direct-mode zero slots after 3-slot pulse", count_zeros(), 13);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule